// File: doc/BRIEF.md
# Age-Ordered Micro-Op Issue Queue with Result Wakeup

This block holds renamed micro-ops between dispatch and execution. Micro-ops enter in program order. Each one carries up to two source tags, each with a ready bit. Every entry receives a sequence number, and the block uses that number to decide which entry is older, including after the counter wraps. Result broadcasts from the execution side wake waiting sources. A second wakeup input serves the load-store side. A load's dependents are released only when that side reports the load complete, which may come many cycles after issue if the access missed the first-level cache.

Address-generation micro-ops for loads and store addresses use the same issue path as ALU micro-ops, but they need the address-generation port instead of the ALU port. Each cycle the block issues at most one micro-op: the oldest entry whose two sources are ready and whose port is free. The issued micro-op states, for each source, whether it must be read from the register file or taken from the bypass network.

A flush removes every entry younger than a given sequence number. Moves, zero idioms and no-ops are removed before dispatch, so they never arrive here.

Top module: `iq_sched`

## Requirements
- R1: After reset the queue is empty: `alloc_ready` is 1, `iss_valid` is 0 and `alloc_seq` is 0.
- R2: Each accepted allocation occupies one entry and advances `alloc_seq` by one. When all DEPTH entries are occupied, `alloc_ready` is 0.
- R3: An entry issues only when both of its source ready bits are set. At most one entry issues per cycle.
- R4: Among the entries that can issue, the one with the oldest sequence number wins. Age is compared modulo 2^SEQ_W, so the order stays correct across counter wraparound.
- R5: An entry with `alloc_is_mem`=1 can issue only while `agu_free`=1. Any other entry can issue only while `alu_free`=1. An entry blocked on its port does not hold back a younger entry whose port is free.
- R6: A pulse on either wakeup input (`wb_valid`/`wb_tag` or `ldw_valid`/`ldw_tag`) marks every waiting source with that tag ready, and the entry can issue in the next cycle. Until such a pulse arrives, broadcasts of other tags leave a load's dependent waiting, however many cycles pass.
- R7: If an allocation and a wakeup carrying the same tag as a new source fall in the same cycle, that source is stored as ready, and the entry can issue in the next cycle.
- R8: `iss_src_byp[k]`=1 (bypass) when source k became ready through a wakeup in the cycle just before the issue cycle. It is 0 (register file) when the source was ready at allocation or was woken earlier than that.
- R9: While `flush_valid`=1, nothing issues and `alloc_ready` is 0. Every entry whose sequence number is strictly younger than `flush_seq` is removed, while older entries and an entry with an equal number stay. The next allocation after the flush takes `flush_seq`+1.
- R10: An issued entry leaves the queue at the next clock edge and issues only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Dispatch offers a micro-op |
| alloc_ready | output | 1 | Queue can accept a micro-op this cycle |
| alloc_op | input | OP_W | Opaque micro-op payload |
| alloc_dst | input | TAG_W | Destination tag |
| alloc_is_mem | input | 1 | Needs the address-generation port |
| alloc_src0 | input | TAG_W | Tag of source 0 |
| alloc_src0_rdy | input | 1 | Source 0 already available |
| alloc_src1 | input | TAG_W | Tag of source 1 |
| alloc_src1_rdy | input | 1 | Source 1 already available |
| alloc_seq | output | SEQ_W | Sequence number the next allocation receives |
| wb_valid | input | 1 | Execution result broadcast valid |
| wb_tag | input | TAG_W | Tag being broadcast |
| ldw_valid | input | 1 | Load-store side reports a load complete |
| ldw_tag | input | TAG_W | Destination tag of that load |
| alu_free | input | 1 | ALU port can accept a micro-op |
| agu_free | input | 1 | Address-generation port can accept a micro-op |
| flush_valid | input | 1 | Remove entries younger than flush_seq |
| flush_seq | input | SEQ_W | Flush boundary sequence number |
| iss_valid | output | 1 | A micro-op issues this cycle |
| iss_op | output | OP_W | Payload of the issued micro-op |
| iss_dst | output | TAG_W | Destination tag of the issued micro-op |
| iss_is_mem | output | 1 | Issued micro-op targets the address-generation port |
| iss_seq | output | SEQ_W | Sequence number of the issued micro-op |
| iss_src_byp | output | 2 | Per source: 1 bypass, 0 register file |

## Verification
The bench builds the queue with DEPTH=4, SEQ_W=4, TAG_W=4 and OP_W=8. With only four entries, the bench can sweep all sixteen ready patterns and then release the waiting entries one at a time through both wakeup inputs. A 4-bit sequence number wraps every sixteen allocations, so the sweep reaches a group of entries that straddles the wrap, and the oldest-first order is checked on that group. The small depth also brings the full-queue and partial-flush boundaries into reach within a few cycles.

// File: rtl/iq_pkg.sv
package iq_pkg;
   // Index of each execution port in the port-free vector.
   localparam int PORT_ALU = 0;
   localparam int PORT_AGU = 1;
   localparam int NPORT    = 2;
   // Number of source operands per micro-op.
   localparam int NSRC     = 2;
endpackage

// File: rtl/iq_slot.sv
module iq_slot #(
   parameter int TAG_W = 6,
   parameter int OP_W  = 8,
   parameter int SEQ_W = 5
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [SEQ_W-1:0]           wr_seq,
   input  logic [OP_W-1:0]            wr_op,
   input  logic [TAG_W-1:0]           wr_dst,
   input  logic                       wr_mem,
   input  logic [1:0][TAG_W-1:0]      wr_tag,
   input  logic [1:0]                 wr_rdy,
   input  logic                       wb_valid,
   input  logic [TAG_W-1:0]           wb_tag,
   input  logic                       ld_valid,
   input  logic [TAG_W-1:0]           ld_tag,
   input  logic                       kill,
   output logic                       o_valid,
   output logic [SEQ_W-1:0]           o_seq,
   output logic [OP_W-1:0]            o_op,
   output logic [TAG_W-1:0]           o_dst,
   output logic                       o_mem,
   output logic [1:0]                 o_rdy,
   output logic [1:0]                 o_byp
);
   logic                  v_q;
   logic [SEQ_W-1:0]      seq_q;
   logic [OP_W-1:0]       op_q;
   logic [TAG_W-1:0]      dst_q;
   logic                  mem_q;
   logic [1:0][TAG_W-1:0] tag_q;
   logic [1:0]            rdy_q, byp_q;
   logic [1:0]            hit_cur, hit_new;

   for (genvar k = 0; k < 2; k++) begin : g_src
      always_comb begin
         hit_cur[k] = (wb_valid && wb_tag == tag_q[k])  || (ld_valid && ld_tag == tag_q[k]);
         hit_new[k] = (wb_valid && wb_tag == wr_tag[k]) || (ld_valid && ld_tag == wr_tag[k]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_q   <= 1'b0;
         seq_q <= '0;
         op_q  <= '0;
         dst_q <= '0;
         mem_q <= 1'b0;
         tag_q <= '0;
         rdy_q <= '0;
         byp_q <= '0;
      end else if (wr_en) begin
         v_q   <= 1'b1;
         seq_q <= wr_seq;
         op_q  <= wr_op;
         dst_q <= wr_dst;
         mem_q <= wr_mem;
         tag_q <= wr_tag;
         rdy_q <= wr_rdy | hit_new;
         byp_q <= ~wr_rdy & hit_new;
      end else if (kill) begin
         v_q   <= 1'b0;
         byp_q <= '0;
      end else if (v_q) begin
         rdy_q <= rdy_q | hit_cur;
         byp_q <= ~rdy_q & hit_cur;
      end else begin
         byp_q <= '0;
      end
   end

   assign o_valid = v_q;
   assign o_seq   = seq_q;
   assign o_op    = op_q;
   assign o_dst   = dst_q;
   assign o_mem   = mem_q;
   assign o_rdy   = rdy_q;
   assign o_byp   = byp_q;

   // R2: the top only writes into an empty slot
   p_wr_into_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !v_q);
   // R7: a tag matched during the write cycle is stored ready
   p_same_cycle_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ((rdy_q & $past(hit_new)) == $past(hit_new)));
   // R8: a bypass mark only ever sits on a ready source
   p_byp_needs_rdy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (byp_q & ~rdy_q) == 2'b00);
   // R9, R10: a killed slot is empty on the next cycle
   p_kill_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (kill && !wr_en) |=> !v_q);
endmodule

// File: rtl/iq_oldest_pick.sv
module iq_oldest_pick #(
   parameter int N     = 8,
   parameter int SEQ_W = 5
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [N-1:0]             elig,
   input  logic [N-1:0][SEQ_W-1:0]  seq,
   output logic [N-1:0]             grant
);
   for (genvar i = 0; i < N; i++) begin : g_cand
      logic beaten;
      always_comb begin
         beaten = 1'b0;
         for (int j = 0; j < N; j++) begin
            logic [SEQ_W-1:0] d;
            d = seq[j] - seq[i];
            // j is older than i when j - i is negative modulo 2^SEQ_W
            if (j != i && elig[j] && d[SEQ_W-1]) beaten = 1'b1;
         end
         grant[i] = elig[i] && !beaten;
      end
   end

   // R3: never more than one winner
   p_single_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   // R4: some eligible entry always wins
   p_some_winner_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|elig) |-> (|grant));
endmodule

// File: rtl/iq_sched.sv
module iq_sched #(
   parameter int DEPTH = 8,
   parameter int TAG_W = 6,
   parameter int OP_W  = 8,
   parameter int SEQ_W = $clog2(DEPTH) + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_valid,
   output logic             alloc_ready,
   input  logic [OP_W-1:0]  alloc_op,
   input  logic [TAG_W-1:0] alloc_dst,
   input  logic             alloc_is_mem,
   input  logic [TAG_W-1:0] alloc_src0,
   input  logic             alloc_src0_rdy,
   input  logic [TAG_W-1:0] alloc_src1,
   input  logic             alloc_src1_rdy,
   output logic [SEQ_W-1:0] alloc_seq,
   input  logic             wb_valid,
   input  logic [TAG_W-1:0] wb_tag,
   input  logic             ldw_valid,
   input  logic [TAG_W-1:0] ldw_tag,
   input  logic             alu_free,
   input  logic             agu_free,
   input  logic             flush_valid,
   input  logic [SEQ_W-1:0] flush_seq,
   output logic             iss_valid,
   output logic [OP_W-1:0]  iss_op,
   output logic [TAG_W-1:0] iss_dst,
   output logic             iss_is_mem,
   output logic [SEQ_W-1:0] iss_seq,
   output logic [1:0]       iss_src_byp
);
   import iq_pkg::*;

   localparam logic [SEQ_W-1:0] SEQ_ONE = SEQ_W'(1);

   // Elaboration-time parameter checks
   if (DEPTH < 2) begin : g_bad_depth
      $error("iq_sched: DEPTH must be at least 2");
   end
   if (SEQ_W < $clog2(DEPTH) + 2) begin : g_bad_seq
      $error("iq_sched: SEQ_W too small for wrap-safe age compare against a flush boundary");
   end
   if (NSRC != 2) begin : g_bad_nsrc
      $error("iq_sched: two sources per entry expected");
   end

   logic [DEPTH-1:0]            e_v, e_mem, wr_oh, kill, elig, grant;
   logic [DEPTH-1:0][SEQ_W-1:0] e_seq;
   logic [DEPTH-1:0][OP_W-1:0]  e_op;
   logic [DEPTH-1:0][TAG_W-1:0] e_dst;
   logic [DEPTH-1:0][1:0]       e_rdy, e_byp;
   logic [NPORT-1:0]            port_free;
   logic [SEQ_W-1:0]            seq_q;
   logic                        alloc_fire;

   assign port_free[PORT_ALU] = alu_free;
   assign port_free[PORT_AGU] = agu_free;

   assign alloc_ready = !(&e_v) && !flush_valid;
   assign alloc_fire  = alloc_valid && alloc_ready;
   assign alloc_seq   = seq_q;

   // Lowest free slot receives the allocation.
   always_comb begin
      logic found;
      found = 1'b0;
      wr_oh = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (!e_v[i] && !found) begin
            wr_oh[i] = alloc_fire;
            found    = 1'b1;
         end
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic [SEQ_W-1:0] fdist;
      logic             younger;
      assign fdist   = e_seq[i] - flush_seq;
      assign younger = !fdist[SEQ_W-1] && (fdist != '0);
      assign kill[i] = grant[i] || (flush_valid && e_v[i] && younger);
      assign elig[i] = e_v[i] && (&e_rdy[i]) && !flush_valid
                       && port_free[e_mem[i] ? PORT_AGU : PORT_ALU];

      iq_slot #(.TAG_W(TAG_W), .OP_W(OP_W), .SEQ_W(SEQ_W)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (wr_oh[i]),
         .wr_seq   (seq_q),
         .wr_op    (alloc_op),
         .wr_dst   (alloc_dst),
         .wr_mem   (alloc_is_mem),
         .wr_tag   ({alloc_src1, alloc_src0}),
         .wr_rdy   ({alloc_src1_rdy, alloc_src0_rdy}),
         .wb_valid (wb_valid),
         .wb_tag   (wb_tag),
         .ld_valid (ldw_valid),
         .ld_tag   (ldw_tag),
         .kill     (kill[i]),
         .o_valid  (e_v[i]),
         .o_seq    (e_seq[i]),
         .o_op     (e_op[i]),
         .o_dst    (e_dst[i]),
         .o_mem    (e_mem[i]),
         .o_rdy    (e_rdy[i]),
         .o_byp    (e_byp[i])
      );
   end

   iq_oldest_pick #(.N(DEPTH), .SEQ_W(SEQ_W)) u_pick (
      .clk   (clk),
      .rst_n (rst_n),
      .elig  (elig),
      .seq   (e_seq),
      .grant (grant)
   );

   always_comb begin
      iss_op      = '0;
      iss_dst     = '0;
      iss_is_mem  = 1'b0;
      iss_seq     = '0;
      iss_src_byp = '0;
      for (int i = 0; i < DEPTH; i++) begin
         iss_op      |= {OP_W{grant[i]}}  & e_op[i];
         iss_dst     |= {TAG_W{grant[i]}} & e_dst[i];
         iss_is_mem  |= grant[i] & e_mem[i];
         iss_seq     |= {SEQ_W{grant[i]}} & e_seq[i];
         iss_src_byp |= {2{grant[i]}}     & e_byp[i];
      end
   end
   assign iss_valid = |grant;

   always_ff @(posedge clk) begin
      if (!rst_n)           seq_q <= '0;
      else if (flush_valid) seq_q <= flush_seq + SEQ_ONE;
      else if (alloc_fire)  seq_q <= seq_q + SEQ_ONE;
   end

   // R2: an allocation without an issue grows the occupancy by one
   p_alloc_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_fire && !iss_valid) |=> ($countones(e_v) == $past($countones(e_v)) + 1));
   // R9: a flush cycle never issues
   p_flush_no_issue_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush_valid |-> !iss_valid);
   // R10: an issue without an allocation shrinks the occupancy by one
   p_issue_leaves_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && !alloc_fire) |=> ($countones(e_v) + 1 == $past($countones(e_v))));
   // R5: the issued micro-op's port was free
   p_port_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |-> (iss_is_mem ? agu_free : alu_free));
endmodule

// File: tb/sim_iq_sched.sv
module sim_iq_sched;
   localparam int D = 4, SW = 4, TW = 4, OW = 8;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n, alloc_valid, alloc_ready, alloc_is_mem;
   logic [OW-1:0] alloc_op, iss_op;
   logic [TW-1:0] alloc_dst, alloc_src0, alloc_src1, wb_tag, ldw_tag, iss_dst;
   logic          alloc_src0_rdy, alloc_src1_rdy, wb_valid, ldw_valid;
   logic          alu_free, agu_free, flush_valid, iss_valid, iss_is_mem;
   logic [SW-1:0] alloc_seq, flush_seq, iss_seq;
   logic [1:0]    iss_src_byp;

   iq_sched #(.DEPTH(D), .TAG_W(TW), .OP_W(OW), .SEQ_W(SW)) u0 (
      .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
      .alloc_op(alloc_op), .alloc_dst(alloc_dst), .alloc_is_mem(alloc_is_mem),
      .alloc_src0(alloc_src0), .alloc_src0_rdy(alloc_src0_rdy),
      .alloc_src1(alloc_src1), .alloc_src1_rdy(alloc_src1_rdy), .alloc_seq(alloc_seq),
      .wb_valid(wb_valid), .wb_tag(wb_tag), .ldw_valid(ldw_valid), .ldw_tag(ldw_tag),
      .alu_free(alu_free), .agu_free(agu_free), .flush_valid(flush_valid),
      .flush_seq(flush_seq), .iss_valid(iss_valid), .iss_op(iss_op), .iss_dst(iss_dst),
      .iss_is_mem(iss_is_mem), .iss_seq(iss_seq), .iss_src_byp(iss_src_byp));

   int n_run = 0, n_bad = 0;
   bit done = 0;

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic nx();
      @(negedge clk); #1;
   endtask

   // Offer one micro-op for one cycle; returns one ns after the next falling edge.
   task automatic alloc(input int op, input int dst, input int t0, input int r0,
                        input int t1, input int r1, input int mem);
      alloc_valid = 1; alloc_op = OW'(op); alloc_dst = TW'(dst); alloc_is_mem = mem[0];
      alloc_src0 = TW'(t0); alloc_src0_rdy = r0[0];
      alloc_src1 = TW'(t1); alloc_src1_rdy = r1[0];
      nx();
      alloc_valid = 0;
   endtask

   initial begin
      rst_n = 0; alloc_valid = 0; alloc_op = '0; alloc_dst = '0; alloc_is_mem = 0;
      alloc_src0 = '0; alloc_src1 = '0; alloc_src0_rdy = 0; alloc_src1_rdy = 0;
      wb_valid = 0; wb_tag = '0; ldw_valid = 0; ldw_tag = '0;
      alu_free = 0; agu_free = 0; flush_valid = 0; flush_seq = '0;
      repeat (3) @(negedge clk);
      rst_n = 1; #1;
      chk("R1 alloc_ready after reset", alloc_ready, 1);
      chk("R1 iss_valid after reset", iss_valid, 0);
      chk("R1 alloc_seq after reset", alloc_seq, 0);

      // One seed entry shifts later groups so that one straddles the wrap.
      alu_free = 1;
      alloc(200, 1, 0, 1, 0, 1, 0);
      chk("R10 seed issues", iss_op, 200);
      chk("R2 seq advanced", alloc_seq, 1);
      nx();
      chk("R10 seed gone", iss_valid, 0);

      // Sweep of all ready patterns over a full queue.
      for (int m = 0; m < 16; m++) begin
         alu_free = 0;
         for (int i = 0; i < 4; i++) alloc(m*4 + i, 8 + i, i + 1, m[i], 0, 1, 0);
         chk("R2 full queue", alloc_ready, 0);
         alu_free = 1; #1;
         for (int i = 0; i < 4; i++) if (m[i]) begin
            chk("R4 oldest ready valid", iss_valid, 1);
            chk("R4 oldest ready first", iss_op, m*4 + i);
            chk("R8 ready at alloc reads rf", iss_src_byp, 0);
            nx();
         end
         chk("R3 waiting entries hold", iss_valid, 0);
         for (int i = 3; i >= 0; i--) if (!m[i]) begin
            if (i % 2 == 0) begin wb_valid = 1; wb_tag = TW'(i + 1); end
            else begin ldw_valid = 1; ldw_tag = TW'(i + 1); end
            #1;
            chk("R6 no issue in wake cycle", iss_valid, 0);
            nx();
            wb_valid = 0; ldw_valid = 0; #1;
            chk("R6 woken entry issues", iss_op, m*4 + i);
            chk("R8 woken source bypassed", iss_src_byp, 1);
            nx();
         end
         chk("R10 drained", iss_valid, 0);
      end

      // Flush: seq now 1; entries take 1..4.
      chk("R4 seq after wraps", alloc_seq, 1);
      alu_free = 1;
      for (int i = 0; i < 4; i++) alloc(100 + i, 0, 12, 0, 0, 1, 0);
      chk("R2 full after four", alloc_ready, 0);
      flush_valid = 1; flush_seq = 4'd2; #1;
      chk("R9 no alloc during flush", alloc_ready, 0);
      nx();
      flush_valid = 0; #1;
      chk("R9 next seq after flush", alloc_seq, 3);
      chk("R9 slots freed", alloc_ready, 1);
      wb_valid = 1; wb_tag = 4'd12;
      nx();
      wb_valid = 0; #1;
      chk("R9 older kept", iss_op, 100);
      chk("R8 bypass right after wake", iss_src_byp, 1);
      nx();
      chk("R9 equal kept", iss_op, 101);
      chk("R8 rf two cycles after wake", iss_src_byp, 0);
      nx();
      chk("R9 younger removed", iss_valid, 0);

      // Same-cycle wake and allocate.
      alu_free = 0; wb_valid = 1; wb_tag = 4'd5;
      alloc(110, 0, 5, 0, 0, 1, 0);
      wb_valid = 0; alu_free = 1; #1;
      chk("R7 same-cycle wake valid", iss_valid, 1);
      chk("R7 same-cycle wake op", iss_op, 110);
      chk("R8 same-cycle wake bypass", iss_src_byp, 1);
      nx();

      // Woken but held one cycle: register file.
      alu_free = 0;
      alloc(111, 0, 6, 0, 0, 1, 0);
      wb_valid = 1; wb_tag = 4'd6;
      nx();
      wb_valid = 0;
      nx();
      alu_free = 1; #1;
      chk("R8 late issue op", iss_op, 111);
      chk("R8 late issue reads rf", iss_src_byp, 0);
      nx();

      // Only one source ready.
      alloc(112, 0, 1, 1, 9, 0, 0);
      chk("R3 half ready holds", iss_valid, 0);
      wb_valid = 1; wb_tag = 4'd9;
      nx();
      wb_valid = 0; #1;
      chk("R3 both ready issues", iss_op, 112);
      chk("R8 per-source select", iss_src_byp, 2);
      nx();

      // Port classes.
      alu_free = 0; agu_free = 0;
      alloc(50, 0, 0, 1, 0, 1, 1);
      alloc(51, 0, 0, 1, 0, 1, 0);
      alu_free = 1; #1;
      chk("R5 younger alu passes blocked agu", iss_op, 51);
      chk("R5 alu class", iss_is_mem, 0);
      nx();
      agu_free = 1; #1;
      chk("R5 agu issues when free", iss_op, 50);
      chk("R5 agu class", iss_is_mem, 1);
      nx();
      alu_free = 0; agu_free = 0;
      alloc(52, 0, 0, 1, 0, 1, 1);
      alloc(53, 0, 0, 1, 0, 1, 0);
      alu_free = 1; agu_free = 1; #1;
      chk("R4 oldest across classes", iss_op, 52);
      nx();
      chk("R4 then younger", iss_op, 53);
      nx();

      // Load dependent waits for load-store completion.
      alu_free = 0; agu_free = 0;
      alloc(60, 7, 0, 1, 0, 1, 1);
      alloc(61, 0, 7, 0, 0, 1, 0);
      alu_free = 1; agu_free = 1; #1;
      chk("R6 load issues", iss_op, 60);
      chk("R6 load dst", iss_dst, 7);
      nx();
      for (int c = 0; c < 3; c++) begin
         wb_valid = 1; wb_tag = 4'd3; #1;
         chk("R6 dependent waits on miss", iss_valid, 0);
         nx();
      end
      wb_valid = 0; ldw_valid = 1; ldw_tag = 4'd7;
      nx();
      ldw_valid = 0; #1;
      chk("R6 dependent after load wake", iss_op, 61);
      chk("R8 load wake bypass", iss_src_byp, 1);
      nx();
      chk("R10 empty at end", iss_valid, 0);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++; n_bad++;
         $display("FAIL watchdog R1..R10 run incomplete actual=hung expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
         $finish;
      end
   end
endmodule